// File: doc/BRIEF.md
# Tiled Background Line Fetcher

This block renders one scanline of a single scrolling text-mode background made of 8x8 tiles. A start pulse captures the layer control word, both 9-bit scroll offsets, the two global block offsets and the scanline number. The block then walks the screen columns from left to right. For each column it reads a 16-bit map entry from video memory, applies the entry's flip bits, reads one tile byte, forms a palette index, and, for a non-zero index, reads a colour from palette memory. Tiles may hold 4 or 8 bits per pixel. Maps may be 256 or 512 pixels wide or tall.

Pixels leave on a valid/ready stream, one per column, in column order. Each pixel carries a 15-bit colour and an opaque flag. While `pix_ready` is low the offered pixel and the whole fetch pipeline stay frozen. No memory is read during that time, so the downstream consumer can stall for any number of cycles without losing data. The three memories are synchronous read ports. Each returns data on the clock edge after its enable was high, and keeps that data while its enable is low.

A parameter selects the main or the secondary engine variant. Only the main variant adds the global 64 KiB block offsets to the map and tile bases.

Top module: `bg_line_fetch`

## Requirements
- R1: While reset is asserted, and after its release until a start is accepted, `pix_valid`, `line_done`, `map_en`, `tile_en` and `pal_en` are all low.
- R2: A start pulse while idle latches every configuration input. The block then delivers exactly LINE_W pixels for columns 0 to LINE_W-1 in order, and `line_done` is high only together with the handshake of the last pixel. A start pulse that arrives before that handshake is ignored and does not change the line being produced.
- R3: With x = scroll_x + column and y = scroll_y + line, both taken mod 512, the map entry address is the screen base plus ((x mod 256)/8)*2 plus ((y mod 256)/8)*64. The screen base is 2048 times layer_ctrl[12:8], plus (main variant only) 65536 times glob_scr_blk. The entry is the little-endian 16-bit word at that even byte address.
- R4: Map size is layer_ctrl[15:14]. Bit 14 adds 0x800 to the map offset when x bit 8 is set. Bit 15 adds 0x800 when y bit 8 is set. When both size bits are set, the row term uses (y mod 512)/8 instead of (y mod 256)/8.
- R5: An entry holds the tile number in bits 9:0, a horizontal flip in bit 10, a vertical flip in bit 11 and a palette bank in bits 15:12. The tile row is y[2:0] XOR 7 when bit 11 is set. The tile column is x[2:0] XOR 7 when bit 10 is set.
- R6: Colour depth is layer_ctrl[7] (1 = 8 bits per pixel). The tile byte address is the char base plus tile*64 + row*8 + column in 8-bit mode, or tile*32 + row*4 + column/2 in 4-bit mode. The char base is 16384 times layer_ctrl[5:2], plus (main variant only) 65536 times glob_chr_blk.
- R7: In 4-bit mode an even column uses the low nibble of the tile byte and an odd column uses the high nibble. A zero nibble gives index 0. Any other nibble gives index bank*16 + nibble. In 8-bit mode the byte itself is the index.
- R8: An index of 0 yields a pixel with `pix_opaque` low and colour 0, and issues no palette read. Any other index reads palette byte address 2*index and outputs that word's bits 14:0 with `pix_opaque` high.
- R9: While `pix_valid` is high and `pix_ready` is low, the offered pixel stays unchanged and no memory enable is raised.
- R10: The secondary variant (MAIN = 0) ignores glob_scr_blk and glob_chr_blk.
- R11: Map and tile addresses wrap modulo 2^VA_W.
- R12: Layer control bits 1:0, 6 and 13 have no effect on the produced pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scanline when idle |
| layer_ctrl | input | 16 | Layer control word |
| scroll_x | input | 9 | Horizontal scroll |
| scroll_y | input | 9 | Vertical scroll |
| glob_scr_blk | input | 3 | Global 64 KiB map block |
| glob_chr_blk | input | 3 | Global 64 KiB tile block |
| line_no | input | 9 | Current scanline |
| map_en | output | 1 | Map entry read enable |
| map_addr | output | VA_W | Map entry byte address |
| map_data | input | 16 | Map entry read data |
| tile_en | output | 1 | Tile byte read enable |
| tile_addr | output | VA_W | Tile byte address |
| tile_data | input | 8 | Tile byte read data |
| pal_en | output | 1 | Palette read enable |
| pal_addr | output | 9 | Palette byte address |
| pal_data | input | 16 | Palette read data |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Consumer accepts pixel |
| pix_color | output | 15 | Pixel colour |
| pix_opaque | output | 1 | Pixel is not transparent |
| line_done | output | 1 | Last pixel of line accepted |

## Verification
The assertions rely on the memories holding their read data while the enable is low. They also rely on reads completing in exactly one cycle. The bench memory models follow both rules, and memory contents are a hash of the address, so every address bit matters. Two lines are run with a pseudo-random `pix_ready` so the stall invariants are exercised. A start pulse is injected in the middle of one line to test the rule that a line cannot be restarted. Both variants run on the same stimulus so the effect of the global offsets can be seen.

// File: rtl/bg_fetch_pkg.sv
package bg_fetch_pkg;

  // Per-line settings captured on an accepted start
  typedef struct packed {
    logic [1:0] size;
    logic [4:0] scr;
    logic       is8;
    logic [3:0] chr;
    logic [8:0] sx;
    logic [8:0] y;
    logic [2:0] gscr;
    logic [2:0] gchr;
  } line_cfg_t;

  localparam int BLK64_SHIFT = 16;

endpackage

// File: rtl/bg_map_addr.sv
module bg_map_addr #(
  parameter int VA_W = 19,
  parameter bit MAIN = 1'b1
) (
  input  logic [5:0]      x_hi,
  input  logic [5:0]      y_hi,
  input  logic [1:0]      size,
  input  logic [4:0]      scr_fld,
  input  logic [2:0]      gscr,
  output logic [VA_W-1:0] addr
);
  import bg_fetch_pkg::*;

  logic [18:0] gterm;
  generate
    if (MAIN) begin : g_main
      assign gterm = {gscr, 16'd0};
    end else begin : g_sub
      logic unused_gscr;
      assign unused_gscr = ^gscr;
      assign gterm = '0;
    end
  endgenerate

  logic [5:0]  yrow;
  logic [12:0] off;

  always_comb begin
    yrow = (size == 2'b11) ? y_hi : {1'b0, y_hi[4:0]};
    off  = 13'({x_hi[4:0], 1'b0}) + 13'({yrow, 6'd0})
         + ((size[0] && x_hi[5]) ? 13'h800 : 13'h000)
         + ((size[1] && y_hi[5]) ? 13'h800 : 13'h000);
  end

  assign addr = VA_W'({scr_fld, 11'd0}) + VA_W'(gterm) + VA_W'(off);

endmodule

// File: rtl/bg_tile_addr.sv
module bg_tile_addr #(
  parameter int VA_W = 19,
  parameter bit MAIN = 1'b1
) (
  input  logic [11:0]     entry,
  input  logic [2:0]      xl,
  input  logic [2:0]      yl,
  input  logic            is8,
  input  logic [3:0]      chr_fld,
  input  logic [2:0]      gchr,
  output logic [VA_W-1:0] addr,
  output logic [2:0]      colf
);
  logic [18:0] gterm;
  generate
    if (MAIN) begin : g_main
      assign gterm = {gchr, 16'd0};
    end else begin : g_sub
      logic unused_gchr;
      assign unused_gchr = ^gchr;
      assign gterm = '0;
    end
  endgenerate

  logic [2:0]  row;
  logic [16:0] toff;

  always_comb begin
    row  = yl ^ {3{entry[11]}};
    colf = xl ^ {3{entry[10]}};
    if (is8)
      toff = 17'({entry[9:0], 6'd0}) + 17'({row, 3'd0}) + 17'(colf);
    else
      toff = 17'({entry[9:0], 5'd0}) + 17'({row, 2'd0}) + 17'(colf[2:1]);
  end

  assign addr = VA_W'({chr_fld, 14'd0}) + VA_W'(gterm) + VA_W'(toff);

endmodule

// File: rtl/bg_pix_index.sv
module bg_pix_index (
  input  logic [7:0] tbyte,
  input  logic       col_lsb,
  input  logic       is8,
  input  logic [3:0] bank,
  output logic [7:0] idx
);
  logic [3:0] nib;

  always_comb begin
    nib = col_lsb ? tbyte[7:4] : tbyte[3:0];
    if (is8)             idx = tbyte;
    else if (nib == 4'd0) idx = 8'd0;
    else                 idx = {bank, nib};
  end

endmodule

// File: rtl/bg_line_fetch.sv
module bg_line_fetch
  import bg_fetch_pkg::*;
#(
  parameter int VA_W   = 19,
  parameter int LINE_W = 256,
  parameter bit MAIN   = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [15:0]     layer_ctrl,
  input  logic [8:0]      scroll_x,
  input  logic [8:0]      scroll_y,
  input  logic [2:0]      glob_scr_blk,
  input  logic [2:0]      glob_chr_blk,
  input  logic [8:0]      line_no,
  output logic            map_en,
  output logic [VA_W-1:0] map_addr,
  input  logic [15:0]     map_data,
  output logic            tile_en,
  output logic [VA_W-1:0] tile_addr,
  input  logic [7:0]      tile_data,
  output logic            pal_en,
  output logic [8:0]      pal_addr,
  input  logic [15:0]     pal_data,
  output logic            pix_valid,
  input  logic            pix_ready,
  output logic [14:0]     pix_color,
  output logic            pix_opaque,
  output logic            line_done
);
  localparam int CW = (LINE_W > 1) ? $clog2(LINE_W) : 1;

  line_cfg_t      cfg;
  logic           active, issuing;
  logic [CW-1:0]  col;
  logic           adv, issue, last_col;
  logic [8:0]     x;

  // stage registers: 1 = entry arriving, 2 = tile byte arriving, 3 = colour arriving
  logic       v1, v2, v3, l1, l2, l3, pix_last;
  logic [2:0] xl1;
  logic       c2;
  logic [3:0] bank2;
  logic       o3;
  logic [2:0] colf;
  logic [7:0] idx;

  logic unused_bits;
  assign unused_bits = pal_data[15] ^ layer_ctrl[13] ^ layer_ctrl[6]
                     ^ layer_ctrl[1] ^ layer_ctrl[0];

  assign adv      = !pix_valid || pix_ready;
  assign last_col = (col == CW'(LINE_W - 1));
  assign issue    = issuing && adv;
  assign x        = cfg.sx + 9'(col);

  bg_map_addr #(.VA_W(VA_W), .MAIN(MAIN)) u_map (
    .x_hi(x[8:3]), .y_hi(cfg.y[8:3]), .size(cfg.size), .scr_fld(cfg.scr),
    .gscr(cfg.gscr), .addr(map_addr)
  );
  assign map_en = issue;

  bg_tile_addr #(.VA_W(VA_W), .MAIN(MAIN)) u_tile (
    .entry(map_data[11:0]), .xl(xl1), .yl(cfg.y[2:0]), .is8(cfg.is8),
    .chr_fld(cfg.chr), .gchr(cfg.gchr), .addr(tile_addr), .colf(colf)
  );
  assign tile_en = adv && v1;

  bg_pix_index u_idx (
    .tbyte(tile_data), .col_lsb(c2), .is8(cfg.is8), .bank(bank2), .idx(idx)
  );
  assign pal_en   = adv && v2 && (idx != 8'd0);
  assign pal_addr = {idx, 1'b0};

  assign line_done = pix_valid && pix_ready && pix_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0; active <= 1'b0; issuing <= 1'b0; col <= '0;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      l1 <= 1'b0; l2 <= 1'b0; l3 <= 1'b0; pix_last <= 1'b0;
      xl1 <= '0; c2 <= 1'b0; bank2 <= '0; o3 <= 1'b0;
      pix_valid <= 1'b0; pix_color <= '0; pix_opaque <= 1'b0;
    end else begin
      if (start && !active) begin
        active   <= 1'b1;
        issuing  <= 1'b1;
        col      <= '0;
        cfg.size <= layer_ctrl[15:14];
        cfg.scr  <= layer_ctrl[12:8];
        cfg.is8  <= layer_ctrl[7];
        cfg.chr  <= layer_ctrl[5:2];
        cfg.sx   <= scroll_x;
        cfg.y    <= scroll_y + line_no;
        cfg.gscr <= glob_scr_blk;
        cfg.gchr <= glob_chr_blk;
      end else if (issue) begin
        col <= col + CW'(1);
        if (last_col) issuing <= 1'b0;
      end
      if (line_done) active <= 1'b0;

      if (adv) begin
        v1  <= issue;
        l1  <= issue && last_col;
        xl1 <= x[2:0];
        v2    <= v1;
        l2    <= l1;
        c2    <= colf[0];
        bank2 <= map_data[15:12];
        v3 <= v2;
        l3 <= l2;
        o3 <= v2 && (idx != 8'd0);
        pix_valid  <= v3;
        pix_last   <= l3;
        pix_opaque <= v3 && o3;
        pix_color  <= (v3 && o3) ? pal_data[14:0] : 15'd0;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_color) && $stable(pix_opaque)); // R9
  AST_STALL_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |-> !map_en && !tile_en && !pal_en); // R9
  AST_CLEAR_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_opaque |-> pix_color == 15'd0); // R8
  AST_PAL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pal_en |-> pal_addr != 9'd0); // R8
  AST_DONE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !pix_valid); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    active && start |=> $stable(cfg)); // R2
  AST_MAP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    map_en |-> !map_addr[0]); // R3

endmodule

// File: tb/tb_bg_line_fetch.sv
`timescale 1ns/1ps
module tb_bg_line_fetch;
  localparam int VA_W = 19;
  localparam int LW   = 256;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, rdy;
  logic [15:0] layer_ctrl;
  logic [8:0]  scroll_x, scroll_y, line_no;
  logic [2:0]  glob_scr_blk, glob_chr_blk;

  logic            m_en [2];
  logic [VA_W-1:0] m_ad [2];
  logic [15:0]     m_dt [2];
  logic            t_en [2];
  logic [VA_W-1:0] t_ad [2];
  logic [7:0]      t_dt [2];
  logic            p_en [2];
  logic [8:0]      p_ad [2];
  logic [15:0]     p_dt [2];
  logic            pv [2];
  logic [14:0]     pc [2];
  logic            po [2];
  logic            pd [2];

  function automatic logic [7:0] hb(input logic [18:0] a);
    logic [31:0] t;
    t = {13'd0, a} * 32'h2C1B3C6D;
    t = t ^ (t >> 13);
    return t[15:8];
  endfunction
  function automatic logic [15:0] mword(input logic [18:0] a);
    return {hb(a + 19'd1), hb(a)};
  endfunction
  function automatic logic [15:0] pword(input logic [8:0] a);
    return {hb({10'h2A5, a}), hb({10'h15A, a})};
  endfunction

  bg_line_fetch #(.VA_W(VA_W), .LINE_W(LW), .MAIN(1'b1)) dut (
    .clk, .rst_n, .start, .layer_ctrl, .scroll_x, .scroll_y, .glob_scr_blk,
    .glob_chr_blk, .line_no, .map_en(m_en[0]), .map_addr(m_ad[0]), .map_data(m_dt[0]),
    .tile_en(t_en[0]), .tile_addr(t_ad[0]), .tile_data(t_dt[0]), .pal_en(p_en[0]),
    .pal_addr(p_ad[0]), .pal_data(p_dt[0]), .pix_valid(pv[0]), .pix_ready(rdy),
    .pix_color(pc[0]), .pix_opaque(po[0]), .line_done(pd[0]));

  bg_line_fetch #(.VA_W(VA_W), .LINE_W(LW), .MAIN(1'b0)) dut_sub (
    .clk, .rst_n, .start, .layer_ctrl, .scroll_x, .scroll_y, .glob_scr_blk,
    .glob_chr_blk, .line_no, .map_en(m_en[1]), .map_addr(m_ad[1]), .map_data(m_dt[1]),
    .tile_en(t_en[1]), .tile_addr(t_ad[1]), .tile_data(t_dt[1]), .pal_en(p_en[1]),
    .pal_addr(p_ad[1]), .pal_data(p_dt[1]), .pix_valid(pv[1]), .pix_ready(rdy),
    .pix_color(pc[1]), .pix_opaque(po[1]), .line_done(pd[1]));

  // synchronous memories: data one edge after enable, held otherwise
  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (m_en[i]) m_dt[i] <= mword(m_ad[i]);
      if (t_en[i]) t_dt[i] <= hb(t_ad[i]);
      if (p_en[i]) p_dt[i] <= pword(p_ad[i]);
    end
  end

  // {ctrl, scroll_x, scroll_y, line, glob_scr, glob_chr, stall}
  localparam logic [49:0] VECS [6] = '{
    {16'h0204, 9'h000, 9'h000, 9'd0,   3'd0, 3'd0, 1'b0},
    {16'h458D, 9'h1F3, 9'h005, 9'd40,  3'd1, 3'd2, 1'b0},
    {16'h894A, 9'h010, 9'h0F8, 9'd20,  3'd3, 3'd1, 1'b0},
    {16'hDFBF, 9'h0A5, 9'h1FE, 9'd150, 3'd7, 3'd7, 1'b0},
    {16'hE418, 9'h120, 9'h133, 9'd100, 3'd2, 3'd5, 1'b1},
    {16'h0080, 9'h0FF, 9'h007, 9'd191, 3'd4, 3'd0, 1'b1}
  };

  // expected pixel {opaque, colour} from the requirements (R3..R8, R10, R11)
  function automatic logic [15:0] ref_px(input logic [49:0] v, input int col, input bit main);
    int unsigned c, size, scr, is8, chr, x, y, gs, gc, off, ma, row, cl, tad, id, idx, nib;
    logic [15:0] e; logic [7:0] b; logic [15:0] pw;
    c = v[49:34]; size = c >> 14; scr = (c >> 8) & 31; is8 = (c >> 7) & 1; chr = (c >> 2) & 15;
    x = (v[33:25] + col) % 512; y = (v[24:16] + v[15:7]) % 512;
    gs = main ? v[6:4] : 0; gc = main ? v[3:1] : 0;
    off = ((x % 256) / 8) * 2 + (((size == 3) ? y % 512 : y % 256) / 8) * 64;
    if ((size & 1) && x >= 256) off += 32'h800;
    if ((size & 2) && y >= 256) off += 32'h800;
    ma = (scr * 2048 + gs * 65536 + off) % (1 << VA_W);
    e = mword(19'(ma));
    id = e[9:0];
    row = (y % 8) ^ (e[11] ? 7 : 0);
    cl  = (x % 8) ^ (e[10] ? 7 : 0);
    if (is8) tad = chr * 16384 + gc * 65536 + id * 64 + row * 8 + cl;
    else     tad = chr * 16384 + gc * 65536 + id * 32 + row * 4 + cl / 2;
    b = hb(19'(tad % (1 << VA_W)));
    if (is8) idx = b;
    else begin
      nib = (cl % 2 == 1) ? b[7:4] : b[3:0];
      idx = (nib == 0) ? 0 : e[15:12] * 16 + nib;
    end
    if (idx == 0) return 16'd0;
    pw = pword(9'(idx * 2));
    return {1'b1, pw[14:0]};
  endfunction

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply_cfg(input logic [49:0] v);
    layer_ctrl = v[49:34]; scroll_x = v[33:25]; scroll_y = v[24:16];
    line_no = v[15:7]; glob_scr_blk = v[6:4]; glob_chr_blk = v[3:1];
  endtask

  task automatic run_line(input logic [49:0] v, input bit inject);
    int got, ncyc, opq [2], prd [2], dn [2];
    logic [7:0] lf;
    logic [15:0] exp, act;
    bit stall;
    got = 0; ncyc = 0; lf = 8'hA5; stall = v[0];
    opq = '{0, 0}; prd = '{0, 0}; dn = '{0, 0};
    @(negedge clk); apply_cfg(v); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (got < LW && ncyc < 6000) begin
      @(negedge clk);
      ncyc++;
      rdy = stall ? (lf[0] | lf[3]) : 1'b1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      start = 1'b0;
      if (inject && ncyc == 60) begin
        apply_cfg(VECS[3]); start = 1'b1;
      end
      #1;
      for (int i = 0; i < 2; i++) begin
        if (p_en[i]) prd[i]++;
        if (pd[i]) dn[i]++;
      end
      if (pv[0] != pv[1])
        chk(1'b0, "R10", "variant valid mismatch", {31'd0, pv[1]}, {31'd0, pv[0]});
      if (pv[0] && rdy) begin
        for (int i = 0; i < 2; i++) begin
          exp = ref_px(v, got, i == 0);
          act = {po[i], pc[i]};
          if (act[15]) opq[i]++;
          chk(act == exp, "R3/R4/R5/R6/R7/R8/R10/R11/R12", "pixel", {16'd0, act}, {16'd0, exp});
          chk(pd[i] == (got == LW - 1), "R2", "done at last pixel", {31'd0, pd[i]},
              {31'd0, got == LW - 1});
        end
        got++;
      end
    end
    start = 1'b0; rdy = 1'b1;
    chk(got == LW, "R2", "pixel count", got, LW);
    for (int i = 0; i < 2; i++) begin
      chk(dn[i] == 1, "R2", "done pulses", dn[i], 1);
      chk(prd[i] == opq[i], "R8", "palette reads vs opaque pixels", prd[i], opq[i]);
    end
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      if (pv[0] || pv[1]) begin
        chk(1'b0, "R2", "pixel after line end", 1, 0);
        break;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rdy = 1'b1;
    apply_cfg(VECS[1]);
    repeat (3) @(negedge clk);
    #1;
    chk(!pv[0] && !pd[0] && !m_en[0] && !t_en[0] && !p_en[0], "R1", "outputs in reset",
        {27'd0, pv[0], pd[0], m_en[0], t_en[0], p_en[0]}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!pv[0] && !pd[0] && !m_en[0] && !t_en[0] && !p_en[0], "R1", "idle after reset",
        {27'd0, pv[0], pd[0], m_en[0], t_en[0], p_en[0]}, 0);

    // vector table: configurations including both ready patterns (R9)
    for (int k = 0; k < 6; k++) run_line(VECS[k], 1'b0);

    // directed: a start pulse mid-line is ignored (R2)
    run_line(VECS[2], 1'b1);
    // directed: priority, mosaic and overflow bits flipped give identical pixels (R12)
    run_line(VECS[0] ^ {16'h2043, 34'd0}, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule